// File: doc/BRIEF.md
# FIFO Occupancy Monitor with Interrupt Flags and DMA Requests

This block watches the occupancy of a serial interface's transmit and receive FIFOs. It does not hold FIFO storage or shift serial data. It takes the entry counts, the full and empty status, and the push and pop attempts from both the bus side and the serial side. From these it drives two DMA request lines, a bank of eight sticky interrupt flags, one combined interrupt line and two FIFO pointer-reset pulses.

The two directions use opposite threshold tests. The transmit side asks for data while its FIFO holds fewer entries than the programmed level. The receive side asks for service while its FIFO holds more entries than its level. Error flags name both the side that made the attempt and the FIFO it touched. Software writes a 1 to a flag bit to clear it. A per-direction clear command resets that FIFO's pointers and drops the flags that belong to it. Each flag has an enable bit at the same position, and the interrupt line is the OR of the enabled flags.

Flag bit positions: 0 transmit below level, 1 transmit empty, 2 receive above level, 3 receive full, 4 transmit overrun, 5 transmit underrun, 6 receive overrun, 7 receive underrun.

Top module: `fifo_level_monitor`

## Requirements
- R1: `txDmaReq` is 1 in the cycle after a clock edge that samples `txDmaEn`=1 and `txCount` < `txLevel`. It is 0 when `txCount` equals `txLevel`.
- R2: `rxDmaReq` is 1 in the cycle after a clock edge that samples `rxDmaEn`=1 and `rxCount` > `rxLevel`. It is 0 when `rxCount` equals `rxLevel`.
- R3: A clock edge that samples a DMA enable at 0 drops that direction's request in the following cycle, whatever the count.
- R4: Flag bit 0 (transmit below level) and flag bit 2 (receive above level) set only on the rising edge of their condition. If a flag is cleared while its condition stays true, it does not set again.
- R5: Flag bit 1 sets on a rising edge of `txEmpty`. Flag bit 3 sets on a rising edge of `rxFull`.
- R6: Flag bit 4 sets after an edge with `busTxPush` and `txFull` both 1. Flag bit 5 sets after an edge with `spiTxPop` and `txEmpty` both 1.
- R7: Flag bit 6 sets after an edge with `spiRxPush` and `rxFull` both 1. Flag bit 7 sets after an edge with `busRxPop` and `rxEmpty` both 1.
- R8: A 1 in bit i of `flagClr` clears flag i at the next edge. Bits written as 0 leave their flags unchanged.
- R9: When a set event and a clear (from `flagClr` or a clear command) reach the same flag in the same cycle, the flag ends up set.
- R10: `irq` equals the OR over i of (`flags[i]` AND `intEnable[i]`), in the same cycle as `flags`.
- R11: `txClearCmd` gives a one-cycle `txPtrReset` pulse in the next cycle and clears flag bits 0, 1, 4 and 5. `rxClearCmd` gives `rxPtrReset` and clears flag bits 2, 3, 6 and 7.
- R12: While `rstN` is 0, all flags, both DMA requests, `irq` and both pointer-reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txCount | input | CNT_W | Transmit FIFO entry count |
| rxCount | input | CNT_W | Receive FIFO entry count |
| txLevel | input | LVL_W | Transmit threshold level |
| rxLevel | input | LVL_W | Receive threshold level |
| txDmaEn | input | 1 | Transmit DMA request enable |
| rxDmaEn | input | 1 | Receive DMA request enable |
| txFull | input | 1 | Transmit FIFO full |
| txEmpty | input | 1 | Transmit FIFO empty |
| rxFull | input | 1 | Receive FIFO full |
| rxEmpty | input | 1 | Receive FIFO empty |
| busTxPush | input | 1 | Bus-side write attempt into transmit FIFO |
| spiTxPop | input | 1 | Serial-side read attempt from transmit FIFO |
| spiRxPush | input | 1 | Serial-side write attempt into receive FIFO |
| busRxPop | input | 1 | Bus-side read attempt from receive FIFO |
| txClearCmd | input | 1 | Transmit FIFO clear command |
| rxClearCmd | input | 1 | Receive FIFO clear command |
| flagClr | input | 8 | Write-one-to-clear strobe per flag |
| intEnable | input | 8 | Interrupt enable per flag |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| flags | output | 8 | Sticky flag bank |
| irq | output | 1 | Combined interrupt |
| txPtrReset | output | 1 | Transmit FIFO pointer reset pulse |
| rxPtrReset | output | 1 | Receive FIFO pointer reset pulse |

## Verification
On every cycle the assertions check the DMA request response to each threshold comparison and to a dropped enable. They also check that overrun and underrun attempts leave their flag set, that a clear command produces its pointer pulse, and that the interrupt stays low when all enables are 0. Edge-only setting of level flags, the set-over-clear priority and the grouping of flags under each clear command depend on history over several cycles. The bench scenarios show these, partly through directed sequences and partly through a reference model running against random stimulus.

// File: rtl/fifo_level_monitor_pkg.sv
package fifo_level_monitor_pkg;

  localparam int NUM_FLAGS = 8;

  // Flag bit positions
  localparam int FL_TX_TH    = 0;
  localparam int FL_TX_EMPTY = 1;
  localparam int FL_RX_TH    = 2;
  localparam int FL_RX_FULL  = 3;
  localparam int FL_TX_OVR   = 4;
  localparam int FL_TX_UND   = 5;
  localparam int FL_RX_OVR   = 6;
  localparam int FL_RX_UND   = 7;

  // Flags owned by each FIFO, dropped by that FIFO's clear command
  localparam logic [NUM_FLAGS-1:0] TX_GROUP =
    NUM_FLAGS'((1 << FL_TX_TH) | (1 << FL_TX_EMPTY) | (1 << FL_TX_OVR) | (1 << FL_TX_UND));
  localparam logic [NUM_FLAGS-1:0] RX_GROUP =
    NUM_FLAGS'((1 << FL_RX_TH) | (1 << FL_RX_FULL) | (1 << FL_RX_OVR) | (1 << FL_RX_UND));

  // Number of flags that follow a level condition through an edge detector
  localparam int NUM_LEVEL_FLAGS = 4;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setEvt;
    logic [NUM_FLAGS-1:0] clrEvt;
    logic                 txReqCond;
    logic                 rxReqCond;
    logic                 txPtrRst;
    logic                 rxPtrRst;
  } monStrobe_t;

endpackage

// File: rtl/fifo_level_monitor_ctrl.sv
module fifo_level_monitor_ctrl
  import fifo_level_monitor_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LVL_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     txCount,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic [LVL_W-1:0]     txLevel,
  input  logic [LVL_W-1:0]     rxLevel,
  input  logic                 txDmaEn,
  input  logic                 rxDmaEn,
  input  logic                 txFull,
  input  logic                 txEmpty,
  input  logic                 rxFull,
  input  logic                 rxEmpty,
  input  logic                 busTxPush,
  input  logic                 spiTxPop,
  input  logic                 spiRxPush,
  input  logic                 busRxPop,
  input  logic                 txClearCmd,
  input  logic                 rxClearCmd,
  input  logic [NUM_FLAGS-1:0] flagClr,
  output monStrobe_t           strobe
);

  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CMP_W-1:0] txCountExt, rxCountExt, txLevelExt, rxLevelExt;
  logic             txBelow, rxAbove;
  logic [NUM_LEVEL_FLAGS-1:0] levelCond;
  logic [NUM_LEVEL_FLAGS-1:0] levelCondPrev;
  logic [NUM_LEVEL_FLAGS-1:0] levelRise;

  assign txCountExt = CMP_W'(txCount);
  assign rxCountExt = CMP_W'(rxCount);
  assign txLevelExt = CMP_W'(txLevel);
  assign rxLevelExt = CMP_W'(rxLevel);

  // The two directions compare in opposite senses
  assign txBelow = txCountExt < txLevelExt;
  assign rxAbove = rxCountExt > rxLevelExt;

  always_comb begin
    levelCond              = '0;
    levelCond[FL_TX_TH]    = txBelow;
    levelCond[FL_TX_EMPTY] = txEmpty;
    levelCond[FL_RX_TH]    = rxAbove;
    levelCond[FL_RX_FULL]  = rxFull;
  end

  // One edge detector per level condition
  genvar g;
  generate
    for (g = 0; g < NUM_LEVEL_FLAGS; g++) begin : gLevelEdge
      always_ff @(posedge clk) begin
        if (!rstN) levelCondPrev[g] <= 1'b0;
        else       levelCondPrev[g] <= levelCond[g];
      end
      assign levelRise[g] = levelCond[g] & ~levelCondPrev[g];
    end
  endgenerate

  always_comb begin
    strobe                              = '0;
    strobe.setEvt[NUM_LEVEL_FLAGS-1:0]  = levelRise;
    strobe.setEvt[FL_TX_OVR]            = busTxPush & txFull;
    strobe.setEvt[FL_TX_UND]            = spiTxPop  & txEmpty;
    strobe.setEvt[FL_RX_OVR]            = spiRxPush & rxFull;
    strobe.setEvt[FL_RX_UND]            = busRxPop  & rxEmpty;
    strobe.clrEvt = flagClr
                  | (txClearCmd ? TX_GROUP : '0)
                  | (rxClearCmd ? RX_GROUP : '0);
    strobe.txReqCond = txDmaEn & txBelow;
    strobe.rxReqCond = rxDmaEn & rxAbove;
    strobe.txPtrRst  = txClearCmd;
    strobe.rxPtrRst  = rxClearCmd;
  end

  // R4: a level flag is never re-armed while its condition was already true
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    levelCondPrev[FL_TX_TH] |-> !strobe.setEvt[FL_TX_TH]);

endmodule

// File: rtl/fifo_level_monitor_dp.sv
module fifo_level_monitor_dp
  import fifo_level_monitor_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  monStrobe_t           strobe,
  input  logic [NUM_FLAGS-1:0] intEnable,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic                 txDmaReq,
  output logic                 rxDmaReq,
  output logic                 irq,
  output logic                 txPtrReset,
  output logic                 rxPtrReset
);

  // Sticky flags: a set event outranks a clear in the same cycle
  genvar g;
  generate
    for (g = 0; g < NUM_FLAGS; g++) begin : gFlag
      always_ff @(posedge clk) begin
        if (!rstN)                 flagQ[g] <= 1'b0;
        else if (strobe.setEvt[g]) flagQ[g] <= 1'b1;
        else if (strobe.clrEvt[g]) flagQ[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDmaReq   <= 1'b0;
      rxDmaReq   <= 1'b0;
      txPtrReset <= 1'b0;
      rxPtrReset <= 1'b0;
    end else begin
      txDmaReq   <= strobe.txReqCond;
      rxDmaReq   <= strobe.rxReqCond;
      txPtrReset <= strobe.txPtrRst;
      rxPtrReset <= strobe.rxPtrRst;
    end
  end

  assign irq = |(flagQ & intEnable);

  // R10: no interrupt with every enable cleared
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == '0) |-> !irq);

  // R9: a set event always leaves its flag high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setEvt[FL_RX_OVR] && strobe.clrEvt[FL_RX_OVR]) |=> flagQ[FL_RX_OVR]);

  // R11: pointer reset is a single-cycle pulse per command
  a_r11_ptr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txPtrRst && !$past(strobe.txPtrRst)) |=> txPtrReset);

endmodule

// File: rtl/fifo_level_monitor.sv
module fifo_level_monitor
  import fifo_level_monitor_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LVL_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     txCount,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic [LVL_W-1:0]     txLevel,
  input  logic [LVL_W-1:0]     rxLevel,
  input  logic                 txDmaEn,
  input  logic                 rxDmaEn,
  input  logic                 txFull,
  input  logic                 txEmpty,
  input  logic                 rxFull,
  input  logic                 rxEmpty,
  input  logic                 busTxPush,
  input  logic                 spiTxPop,
  input  logic                 spiRxPush,
  input  logic                 busRxPop,
  input  logic                 txClearCmd,
  input  logic                 rxClearCmd,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic [NUM_FLAGS-1:0] intEnable,
  output logic                 txDmaReq,
  output logic                 rxDmaReq,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq,
  output logic                 txPtrReset,
  output logic                 rxPtrReset
);

  monStrobe_t strobe;

  fifo_level_monitor_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txDmaEn    (txDmaEn),
    .rxDmaEn    (rxDmaEn),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .busTxPush  (busTxPush),
    .spiTxPop   (spiTxPop),
    .spiRxPush  (spiRxPush),
    .busRxPop   (busRxPop),
    .txClearCmd (txClearCmd),
    .rxClearCmd (rxClearCmd),
    .flagClr    (flagClr),
    .strobe     (strobe)
  );

  fifo_level_monitor_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .intEnable  (intEnable),
    .flagQ      (flags),
    .txDmaReq   (txDmaReq),
    .rxDmaReq   (rxDmaReq),
    .irq        (irq),
    .txPtrReset (txPtrReset),
    .rxPtrReset (rxPtrReset)
  );

  // R1: transmit request follows the below-level test
  a_r1_tx_req: assert property (@(posedge clk) disable iff (!rstN)
    (txDmaEn && (CNT_W'(txCount) < CNT_W'(txLevel))) |=> txDmaReq);

  // R2: receive request follows the above-level test
  a_r2_rx_req: assert property (@(posedge clk) disable iff (!rstN)
    (rxDmaEn && (CNT_W'(rxCount) > CNT_W'(rxLevel))) |=> rxDmaReq);

  // R3: a disabled direction never keeps a request
  a_r3_tx_off: assert property (@(posedge clk) disable iff (!rstN)
    !txDmaEn |=> !txDmaReq);
  a_r3_rx_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxDmaEn |=> !rxDmaReq);

  // R6: bus write into a full transmit FIFO is recorded
  a_r6_tx_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (busTxPush && txFull) |=> flags[FL_TX_OVR]);

  // R7: bus read from an empty receive FIFO is recorded
  a_r7_rx_und: assert property (@(posedge clk) disable iff (!rstN)
    (busRxPop && rxEmpty) |=> flags[FL_RX_UND]);

endmodule

// File: tb/tb_fifo_level_monitor.sv
module tb_fifo_level_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] txCount = '0, rxCount = '0, txLevel = '0, rxLevel = '0;
  logic       txDmaEn = 0, rxDmaEn = 0, txFull = 0, txEmpty = 0, rxFull = 0, rxEmpty = 0;
  logic       busTxPush = 0, spiTxPop = 0, spiRxPush = 0, busRxPop = 0;
  logic       txClearCmd = 0, rxClearCmd = 0;
  logic [7:0] flagClr = '0, intEnable = '0;
  logic       txDmaReq, rxDmaReq, irq, txPtrReset, rxPtrReset;
  logic [7:0] flags;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  logic [7:0] mFlags = '0;
  logic [3:0] mPrev = '0;
  logic mTxReq = 0, mRxReq = 0, mTxPr = 0, mRxPr = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  fifo_level_monitor dut (
    .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
    .txLevel(txLevel), .rxLevel(rxLevel), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .busTxPush(busTxPush), .spiTxPop(spiTxPop), .spiRxPush(spiRxPush),
    .busRxPop(busRxPop), .txClearCmd(txClearCmd), .rxClearCmd(rxClearCmd),
    .flagClr(flagClr), .intEnable(intEnable), .txDmaReq(txDmaReq),
    .rxDmaReq(rxDmaReq), .flags(flags), .irq(irq), .txPtrReset(txPtrReset),
    .rxPtrReset(rxPtrReset)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expectIrq(input logic [7:0] f, input logic [7:0] en);
    return {7'b0, |(f & en)};
  endfunction

  // Model update from the requirements, evaluated at each rising edge
  task automatic modelEdge();
    logic       below, above;
    logic [3:0] cond;
    logic [7:0] setV, clrV;
    if (!rstN) begin
      mFlags = '0; mPrev = '0; mTxReq = 0; mRxReq = 0; mTxPr = 0; mRxPr = 0;
      return;
    end
    below = txCount < txLevel;   // R1
    above = rxCount > rxLevel;   // R2
    cond  = {rxFull, above, txEmpty, below};
    setV[3:0] = cond & ~mPrev;   // R4, R5
    setV[4] = busTxPush & txFull;   // R6
    setV[5] = spiTxPop & txEmpty;
    setV[6] = spiRxPush & rxFull;   // R7
    setV[7] = busRxPop & rxEmpty;
    clrV = flagClr | (txClearCmd ? 8'h33 : 8'h00) | (rxClearCmd ? 8'hCC : 8'h00); // R8, R11
    mFlags = setV | (mFlags & ~clrV);  // R9
    mPrev  = cond;
    mTxReq = txDmaEn & below;   // R3
    mRxReq = rxDmaEn & above;
    mTxPr  = txClearCmd;
    mRxPr  = rxClearCmd;
  endtask

  task automatic compareAll();
    check("txDmaReq R1/R3", {7'b0, txDmaReq}, {7'b0, mTxReq});
    check("rxDmaReq R2/R3", {7'b0, rxDmaReq}, {7'b0, mRxReq});
    check("flags R4 R5 R6 R7 R8 R9", flags, mFlags);
    check("irq R10", {7'b0, irq}, expectIrq(mFlags, intEnable));
    check("txPtrReset R11", {7'b0, txPtrReset}, {7'b0, mTxPr});
    check("rxPtrReset R11", {7'b0, rxPtrReset}, {7'b0, mRxPr});
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic quiet();
    busTxPush = 0; spiTxPop = 0; spiRxPush = 0; busRxPop = 0;
    txClearCmd = 0; rxClearCmd = 0; flagClr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R12: reset state
    repeat (3) cycle();
    check("R12 flags in reset", flags, 8'h00);
    check("R12 dma in reset", {6'b0, txDmaReq, rxDmaReq}, 8'h00);
    check("R12 irq/ptr in reset", {5'b0, irq, txPtrReset, rxPtrReset}, 8'h00);
    rstN = 1;
    cycle();

    // R1: below level requests; equal does not
    txLevel = 6'd5; txCount = 6'd3; txDmaEn = 1;
    cycle();
    check("R1 req below level", {7'b0, txDmaReq}, 8'h01);
    check("R4 tx flag on rising edge", {7'b0, flags[0]}, 8'h01);
    txCount = 6'd5;
    cycle();
    check("R1 no req at equal", {7'b0, txDmaReq}, 8'h00);

    // R3: disabling drops request
    txCount = 6'd2; txDmaEn = 0;
    cycle();
    check("R3 disabled tx req", {7'b0, txDmaReq}, 8'h00);

    // R4: clear while condition holds, no re-set
    flagClr = 8'h01;
    cycle();
    quiet();
    check("R4 cleared", {7'b0, flags[0]}, 8'h00);
    cycle();
    check("R4 stays clear while condition held", {7'b0, flags[0]}, 8'h00);

    // R2
    rxLevel = 6'd4; rxCount = 6'd4; rxDmaEn = 1;
    cycle();
    check("R2 no req at equal", {7'b0, rxDmaReq}, 8'h00);
    rxCount = 6'd5;
    cycle();
    check("R2 req above level", {7'b0, rxDmaReq}, 8'h01);
    check("R4 rx flag", {7'b0, flags[2]}, 8'h01);

    // R5
    txEmpty = 1;
    cycle();
    check("R5 tx empty flag", {7'b0, flags[1]}, 8'h01);
    rxFull = 1;
    cycle();
    check("R5 rx full flag", {7'b0, flags[3]}, 8'h01);

    // R6
    txFull = 1; busTxPush = 1;
    cycle();
    quiet(); txFull = 0;
    check("R6 tx overrun", {7'b0, flags[4]}, 8'h01);
    spiTxPop = 1;
    cycle();
    quiet();
    check("R6 tx underrun", {7'b0, flags[5]}, 8'h01);

    // R7
    spiRxPush = 1;
    cycle();
    quiet();
    check("R7 rx overrun", {7'b0, flags[6]}, 8'h01);
    rxEmpty = 1; busRxPop = 1;
    cycle();
    quiet(); rxEmpty = 0;
    check("R7 rx underrun", {7'b0, flags[7]}, 8'h01);

    // R10
    intEnable = 8'h00;
    cycle();
    check("R10 irq masked", {7'b0, irq}, 8'h00);
    intEnable = 8'h80;
    cycle();
    check("R10 irq enabled bit", {7'b0, irq}, 8'h01);

    // R11: transmit clear
    txClearCmd = 1;
    cycle();
    quiet();
    check("R11 tx ptr pulse", {7'b0, txPtrReset}, 8'h01);
    check("R11 tx group cleared", flags & 8'h33, 8'h00);
    check("R11 rx group kept", flags & 8'hCC, 8'hCC);
    cycle();
    check("R11 tx ptr one cycle", {7'b0, txPtrReset}, 8'h00);

    // R9: rx clear together with rx overrun event
    rxClearCmd = 1; spiRxPush = 1;
    cycle();
    quiet();
    check("R9 set beats clear", {7'b0, flags[6]}, 8'h01);
    check("R11 rx ptr pulse", {7'b0, rxPtrReset}, 8'h01);
    check("R11 rx flag bit2 cleared", {7'b0, flags[2]}, 8'h00);

    // R8: single-bit clear leaves others alone
    flagClr = 8'h40;
    cycle();
    quiet();
    check("R8 w1c bit6", {7'b0, flags[6]}, 8'h00);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      txCount   = 6'($urandom_range(0, 12));
      rxCount   = 6'($urandom_range(0, 12));
      if ($urandom_range(0, 15) == 0) txLevel = 6'($urandom_range(0, 12));
      if ($urandom_range(0, 15) == 0) rxLevel = 6'($urandom_range(0, 12));
      if ($urandom_range(0, 7) == 0) txDmaEn = 1'($urandom);
      if ($urandom_range(0, 7) == 0) rxDmaEn = 1'($urandom);
      txFull    = ($urandom_range(0, 3) == 0);
      txEmpty   = ($urandom_range(0, 3) == 0);
      rxFull    = ($urandom_range(0, 3) == 0);
      rxEmpty   = ($urandom_range(0, 3) == 0);
      busTxPush = 1'($urandom);
      spiTxPop  = 1'($urandom);
      spiRxPush = 1'($urandom);
      busRxPop  = 1'($urandom);
      txClearCmd = ($urandom_range(0, 19) == 0);
      rxClearCmd = ($urandom_range(0, 19) == 0);
      flagClr   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      if ($urandom_range(0, 9) == 0) intEnable = 8'($urandom);
      cycle();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule